// File: doc/BRIEF.md
# Serial Converter Output Port Model

This block is a synthesizable stand-in for the digital side of a sampling converter with a three-wire serial output. A host read controller under test drives a conversion-start line and a serial clock. The model replies on a serial data line, so the host logic can be exercised without any analog hardware. The value to be "converted" comes from a parallel input. It is captured when a conversion starts and then shifted out most significant bit first.

A rising edge on the conversion-start line captures the sample and turns the serial output off. The model then counts a programmable number of system-clock cycles of conversion and waits in acquisition. When the start line falls, the most significant bit appears at once, without any clock edge. Each later falling serial-clock edge moves the next lower bit onto the line. Once all bits have gone out, the line stays low. If the host drops the start line before the conversion count has run out, the model raises an early-read flag. The flag is cleared by the next conversion start.

Both host lines are asynchronous to the model's clock. Each passes through a synchronizer, and edges are detected on the synchronized copies. The tri-state output is split into a data bit and an output-enable bit.

Top module: `adc_port_model`

## Requirements
- R1: The third rising `clk` edge after `cnv_in` rises captures `sample_in`, and from that edge `sdo_oe` is 0 and `sdo_data` is 0.
- R2: After a conversion start, the model is converting for `conv_cycles` clock cycles. A value of 0 means acquisition begins immediately. A `cnv_in` fall that arrives after the count has run out leaves `early_read_flag` at 0.
- R3: On the third rising `clk` edge after `cnv_in` falls, `sdo_oe` becomes 1 and `sdo_data` equals bit DATA_W-1 of the captured sample. No `sck_in` edge is needed.
- R4: While `cnv_in` is low, each falling edge of `sck_in` puts the next lower captured bit on `sdo_data`, three `clk` edges later. The k-th falling edge (k = 1..DATA_W-1) presents bit DATA_W-1-k.
- R5: From the DATA_W-th falling `sck_in` edge of a read onward, `sdo_data` is 0 while `sdo_oe` stays 1, however many further edges arrive.
- R6: `sdo_oe` is 1 only while the synchronized `cnv_in` is low after a fall. A rise in the middle of a read turns it off, and `sdo_data` is 0 whenever `sdo_oe` is 0.
- R7: A `cnv_in` fall that arrives while the conversion count has not run out sets `early_read_flag`. The flag stays set through the read and clears on the next conversion start.
- R8: Each host line passes through a SYNC_STAGES-deep synchronizer plus one edge register. With the default of 2 stages, a port reacts on exactly the third rising `clk` edge after its input changes, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_in | input | 1 | Conversion start / read select from the host (asynchronous) |
| sck_in | input | 1 | Serial clock from the host (asynchronous) |
| sample_in | input | DATA_W | Parallel value captured at conversion start |
| conv_cycles | input | CNT_W | Conversion time in `clk` cycles |
| sdo_data | output | 1 | Serial data value (0 when not enabled) |
| sdo_oe | output | 1 | Output enable of the serial data pin |
| early_read_flag | output | 1 | Set when a read starts before conversion completes |

## Verification
A stuck phase or a wrong conversion count shows up at the ports within one read. The output enable or the early-read flag takes the wrong value on the third clock edge after the `cnv_in` fall. A corrupted shift register or shift counter shows on `sdo_data` at the first serial-clock fall it affects, three clock edges after that fall. A stale capture register shows in the most significant bit of the very next read. Randomized samples and conversion times are checked bit by bit against a bench model, alongside directed runs for latency, early reads, aborted reads and clocking past the last bit.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_CONVERT = 2'd1,
    PH_ACQUIRE = 2'd2,
    PH_READ    = 2'd3
  } phase_t;

  // Shift one position toward the MSB, filling with zero so the line idles low.
  function automatic logic [63:0] shift_in_zero(input logic [63:0] v);
    return {v[62:0], 1'b0};
  endfunction

  // Saturating increment used for the shift counter.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      last  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~last;
  assign fall  = ~chain[STAGES-1] & last;
endmodule

// File: rtl/conv_timer.sv
module conv_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cycles,
  output logic             converting
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (start) begin
      remain <= cycles;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign converting = (remain != '0);
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter
  import adc_port_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int CW = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  output logic              head_bit,
  output logic              next_bit,
  output logic [CW-1:0]     shifted
);
  logic [DATA_W-1:0] sreg;
  logic [63:0]       widened;
  logic [63:0]       moved;

  always_comb begin
    widened = '0;
    widened[DATA_W-1:0] = sreg;
    moved = shift_in_zero(widened);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg    <= '0;
      shifted <= '0;
    end else if (load) begin
      sreg    <= load_val;
      shifted <= '0;
    end else if (shift) begin
      sreg    <= moved[DATA_W-1:0];
      shifted <= CW'(sat_inc(int'(shifted), DATA_W));
    end
  end

  assign head_bit = sreg[DATA_W-1];
  assign next_bit = sreg[DATA_W-2];
endmodule

// File: rtl/adc_port_model.sv
module adc_port_model
  import adc_port_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_in,
  input  logic              sck_in,
  input  logic [DATA_W-1:0] sample_in,
  input  logic [CNT_W-1:0]  conv_cycles,
  output logic              sdo_data,
  output logic              sdo_oe,
  output logic              early_read_flag
);
  // index 0: conversion line, index 1: serial clock
  logic [1:0] raw_in, lvl, rise_e, fall_e;
  assign raw_in = {sck_in, cnv_in};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(raw_in[g]),
      .level(lvl[g]), .rise(rise_e[g]), .fall(fall_e[g])
    );
  end

  // Named internal events for the checker
  logic cnv_rise_evt, cnv_fall_evt, sck_fall_evt, converting, shift_evt;
  assign cnv_rise_evt = rise_e[0];
  assign cnv_fall_evt = fall_e[0];
  assign sck_fall_evt = fall_e[1];

  conv_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(cnv_rise_evt),
    .cycles(conv_cycles), .converting(converting)
  );

  phase_t            phase;
  logic [DATA_W-1:0] sample_q;
  logic              early_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      sample_q <= '0;
      early_q  <= 1'b0;
    end else begin
      if (cnv_rise_evt) begin
        phase    <= PH_CONVERT;
        sample_q <= sample_in;
        early_q  <= 1'b0;
      end else if (cnv_fall_evt) begin
        phase <= PH_READ;
        if (converting) early_q <= 1'b1;
      end else if (phase == PH_CONVERT && !converting) begin
        phase <= PH_ACQUIRE;
      end
    end
  end

  assign shift_evt = sck_fall_evt && (phase == PH_READ) && lvl[0] == 1'b0;

  logic          head_bit, next_bit;
  logic [CW-1:0] shifted;

  serial_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(cnv_fall_evt), .load_val(sample_q),
    .shift(shift_evt),
    .head_bit(head_bit), .next_bit(next_bit), .shifted(shifted)
  );

  assign sdo_oe          = (phase == PH_READ);
  assign sdo_data        = sdo_oe & head_bit;
  assign early_read_flag = early_q;
endmodule

// File: rtl/adc_port_model_chk.sv
module adc_port_model_chk #(
  parameter int DATA_W = 16,
  localparam int CW = $clog2(DATA_W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnv_rise_evt,
  input logic          cnv_fall_evt,
  input logic          shift_evt,
  input logic          converting,
  input logic          sample_msb,
  input logic          next_bit,
  input logic [CW-1:0] shifted,
  input logic          sdo_data,
  input logic          sdo_oe,
  input logic          early_read_flag
);
  p_oe_off_at_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_rise_evt |=> !sdo_oe);

  p_msb_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_fall_evt |=> (sdo_oe && sdo_data == $past(sample_msb)));

  p_next_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && !cnv_rise_evt) |=> (sdo_data == $past(next_bit) || $past(shifted) >= CW'(DATA_W - 1)));

  p_low_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && shifted == CW'(DATA_W)) |-> !sdo_data);

  p_data_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo_data);

  p_oe_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnv_rise_evt && !cnv_fall_evt) |=> $stable(sdo_oe));

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_fall_evt && converting) |=> early_read_flag);

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_rise_evt |=> !early_read_flag);

  p_flag_late_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_fall_evt && !converting && !early_read_flag) |=> !early_read_flag);
endmodule

bind adc_port_model adc_port_model_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cnv_rise_evt(cnv_rise_evt), .cnv_fall_evt(cnv_fall_evt),
  .shift_evt(shift_evt), .converting(converting),
  .sample_msb(sample_q[DATA_W-1]), .next_bit(next_bit), .shifted(shifted),
  .sdo_data(sdo_data), .sdo_oe(sdo_oe), .early_read_flag(early_read_flag)
);

// File: tb/adc_port_model_bench.sv
module adc_port_model_bench;
  localparam int DW = 16;
  localparam int CWB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv_in = 1'b0;
  logic sck_in = 1'b0;
  logic [DW-1:0] sample_in = '0;
  logic [CWB-1:0] conv_cycles = '0;
  logic sdo_data, sdo_oe, early_read_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_port_model u_adc_port_model (
    .clk(clk), .rst_n(rst_n), .cnv_in(cnv_in), .sck_in(sck_in),
    .sample_in(sample_in), .conv_cycles(conv_cycles),
    .sdo_data(sdo_data), .sdo_oe(sdo_oe), .early_read_flag(early_read_flag)
  );

  function automatic logic exp_bit(input logic [DW-1:0] s, input int k);
    return (k < DW) ? s[DW-1-k] : 1'b0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cnv(input logic v);
    @(negedge clk);
    cnv_in = v;
    wait_cyc(5);
  endtask

  task automatic sck_pulse();
    @(negedge clk); sck_in = 1'b1; wait_cyc(4);
    sck_in = 1'b0; wait_cyc(5);
  endtask

  // Full read with bit-by-bit check; extra = falls beyond DW
  task automatic do_frame(input logic [DW-1:0] s, input int cyc, input int extra);
    @(negedge clk);
    sample_in = s; conv_cycles = CWB'(cyc);
    set_cnv(1'b1);
    check("R1 oe after start", int'(sdo_oe), 0);
    check("R1 data after start", int'(sdo_data), 0);
    sample_in = ~s;
    wait_cyc(cyc + 4);
    set_cnv(1'b0);
    check("R2 no flag after late fall", int'(early_read_flag), 0);
    check("R3 oe on fall", int'(sdo_oe), 1);
    check("R3 msb on fall", int'(sdo_data), int'(exp_bit(s, 0)));
    for (int k = 1; k < DW + extra; k++) begin
      sck_pulse();
      if (k < DW) check("R4 shifted bit", int'(sdo_data), int'(exp_bit(s, k)));
      else begin
        check("R5 low after last bit", int'(sdo_data), 0);
        check("R5 oe held", int'(sdo_oe), 1);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    wait_cyc(3);
    check("R1 reset oe", int'(sdo_oe), 0);
    check("R1 reset data", int'(sdo_data), 0);
    check("R7 reset flag", int'(early_read_flag), 0);
    rst_n = 1'b1;
    wait_cyc(2);

    // Directed patterns, including zero conversion time
    do_frame(16'hA5C3, 10, 3);
    do_frame(16'hFFFF, 0, 2);
    do_frame(16'h8001, 1, 1);

    // R8: latency on fall and rise
    @(negedge clk); sample_in = 16'h8000; conv_cycles = 16'd5;
    set_cnv(1'b1); wait_cyc(10);
    @(negedge clk); cnv_in = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    check("R8 oe not yet after 2 edges", int'(sdo_oe), 0);
    @(posedge clk); #1;
    check("R8 oe on 3rd edge", int'(sdo_oe), 1);
    wait_cyc(3);
    @(negedge clk); cnv_in = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R8 oe held after 2 edges", int'(sdo_oe), 1);
    @(posedge clk); #1;
    check("R8 oe off on 3rd edge", int'(sdo_oe), 0);
    wait_cyc(10);
    set_cnv(1'b0);

    // R6: abort mid-read, then sck while high has no effect on output
    @(negedge clk); sample_in = 16'hF0F0; conv_cycles = 16'd3;
    set_cnv(1'b1); wait_cyc(8);
    set_cnv(1'b0);
    sck_pulse(); sck_pulse();
    check("R4 bit2 before abort", int'(sdo_data), 1);
    set_cnv(1'b1);
    check("R6 oe off after mid-read rise", int'(sdo_oe), 0);
    sck_pulse();
    check("R6 data low while off", int'(sdo_data), 0);
    check("R6 oe stays off with sck", int'(sdo_oe), 0);
    wait_cyc(8);
    set_cnv(1'b0);
    check("R6 new read restarts at msb", int'(sdo_data), 1);

    // R7: early read
    @(negedge clk); sample_in = 16'h4000; conv_cycles = 16'd300;
    set_cnv(1'b1); wait_cyc(20);
    set_cnv(1'b0);
    check("R7 flag set on early fall", int'(early_read_flag), 1);
    sck_pulse();
    check("R7 flag held during read", int'(early_read_flag), 1);
    check("R4 early read still shifts", int'(sdo_data), 1);
    @(negedge clk); conv_cycles = 16'd4;
    set_cnv(1'b1);
    check("R7 flag cleared on start", int'(early_read_flag), 0);
    wait_cyc(10);
    set_cnv(1'b0);
    check("R2 late fall no flag", int'(early_read_flag), 0);

    // Random frames
    for (int i = 0; i < 10; i++) begin
      do_frame(DW'($urandom), int'($urandom_range(0, 40)), int'($urandom_range(0, 3)));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule